// File: doc/BRIEF.md
# Sample-Rate Frame Timing Generator

This block produces the conversion-rate timing for a sigma-delta codec serial port. It runs on a core clock that is a fixed multiple (`CLK_PER_MCLK`) of the master clock. It divides that clock down to a serial bit clock and a primary frame sync. A single mode bit selects the divide path. When the bit is 0, one conversion period lasts 128×N master clocks; this path stands in for the phase-locked path and is modelled as a plain digital divider. When the bit is 1, one conversion period lasts 512×N master clocks; this is the bypass path. N is a 5-bit unsigned divisor, and a value of 0 is treated as 1.

Every frame holds `FRAME_SCLKS` bit-clock periods, 256 by default. The frame sync is low for the first bit-clock period of each frame, and its falling edge marks the start of a conversion period. A one-clock strobe marks the same moment. The mode bit and N are sampled only at a frame boundary, so software may change them at any time without producing a short or torn frame. A flag warns when the 128×N path is selected with a divisor that puts the sample rate below the low-rate threshold for the configured master clock. Such a setting must use the 512×N path instead.

Top module: `ftg_top`

## Requirements
- R1: While reset is asserted, sclk_o and fsync_o are 1 and frame_start_o and low_rate_o are 0. After reset is released, the first frame begins on the third rising clock edge, and frame_start_o is high after that edge.
- R2: A divisor input of 0 gives exactly the same timing as a divisor of 1.
- R3: With the mode bit at 0, sclk_o is a square wave whose half period is HALF_UNIT×N clocks. HALF_UNIT = BASE_DIV×CLK_PER_MCLK/(2×FRAME_SCLKS). A frame therefore lasts 128×N master clocks (128×N×CLK_PER_MCLK core clocks).
- R4: With the mode bit at 1, the half period of sclk_o is four times as long as in R3, and a frame lasts 512×N master clocks.
- R5: fsync_o is low for exactly one sclk_o period per frame. It falls together with the falling edge of sclk_o that opens the frame, and it rises at the next falling edge of sclk_o.
- R6: frame_start_o is high for exactly one clock per frame, in the same clock in which fsync_o first reads low.
- R7: A change to the mode bit or to N during a frame leaves the length of that frame unchanged. The new values govern the frame that begins at the next boundary.
- R8: low_rate_o is 1 for a frame exactly when that frame's configuration has the mode bit at 0 and MCLK_HZ < LOW_RATE_HZ×BASE_DIV×N. The flag changes only at a frame boundary.
- R9: Each frame contains exactly FRAME_SCLKS rising edges of sclk_o, and sclk_o is 0 in the first clock of the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock, CLK_PER_MCLK times the master clock rate |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| div_sel_i | input | 1 | Divide-path select: 0 = 128×N, 1 = 512×N (PLL bypass) |
| div_n_i | input | N_W | Rate divisor N; 0 is treated as 1 |
| sclk_o | output | 1 | Serial bit clock |
| fsync_o | output | 1 | Primary frame sync, active low for the first bit of each frame |
| frame_start_o | output | 1 | One-clock strobe at the start of each conversion period |
| low_rate_o | output | 1 | 128×N path selected below the low-rate threshold |

## Verification
The bench builds the block with FRAME_SCLKS = 16, CLK_PER_MCLK = 1 and MCLK_HZ = 12,288,000. The short frame makes a mode-0 frame 128×N clocks long and keeps the sclk half period at an integral 4×N clocks. Many complete frames in both modes, and a divisor change in the middle of a frame, therefore fit in a short run. With this master-clock value the low-rate threshold falls between N = 13 and N = 14, so the bench can drive the flag on and off with neighbouring divisors. The same divisor under mode 1 shows that the flag is suppressed on the bypass path.

// File: rtl/ftg_pkg.sv
package ftg_pkg;

  // Divide-path selection held in the active configuration.
  typedef enum logic {
    DIV_LOW  = 1'b0,  // 128 x N path
    DIV_HIGH = 1'b1   // 512 x N bypass path
  } div_mode_e;

  // Ratio between the bypass path and the direct path.
  localparam int unsigned MODE1_MULT = 4;

endpackage

// File: rtl/ftg_rst_sync.sv
module ftg_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_no = sync_q[1];

endmodule

// File: rtl/ftg_cfg_reg.sv
module ftg_cfg_reg
  import ftg_pkg::*;
#(
  parameter int unsigned N_W         = 5,
  parameter int unsigned HALF_UNIT   = 1,
  parameter int unsigned HALF_W      = 7,
  parameter int unsigned BASE_DIV    = 128,
  parameter int unsigned MCLK_HZ     = 12_288_000,
  parameter int unsigned LOW_RATE_HZ = 7000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              boundary_i,
  input  logic              div_sel_i,
  input  logic [N_W-1:0]    div_n_i,
  output logic [HALF_W-1:0] reload_len_o,
  output logic              low_rate_o
);

  div_mode_e          sel_q;
  logic [N_W-1:0]     n_q;
  logic               low_q;

  div_mode_e          sel_new;
  logic [N_W-1:0]     n_new;
  logic               low_new;
  logic [63:0]        thresh_new;
  logic               cfg_en;

  function automatic logic [HALF_W-1:0] half_len(input div_mode_e sel,
                                                 input logic [N_W-1:0] n);
    logic [HALF_W-1:0] base;
    base = HALF_W'(HALF_UNIT) * HALF_W'(n);
    if (sel == DIV_HIGH) begin
      base = base * HALF_W'(MODE1_MULT);
    end
    return base;
  endfunction

  // Candidate configuration taken from the inputs.
  always_comb begin
    sel_new    = div_mode_e'(div_sel_i);
    n_new      = (div_n_i == '0) ? N_W'(1) : div_n_i;
    thresh_new = 64'(LOW_RATE_HZ) * 64'(BASE_DIV) * 64'(n_new);
    low_new    = (sel_new == DIV_LOW) && (64'(MCLK_HZ) < thresh_new);
    cfg_en     = boundary_i;
  end

  // The half-period counter reloads with the new setting on a boundary.
  always_comb begin
    if (boundary_i) begin
      reload_len_o = half_len(sel_new, n_new);
    end else begin
      reload_len_o = half_len(sel_q, n_q);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= DIV_HIGH;
      n_q   <= N_W'(1);
      low_q <= 1'b0;
    end else if (cfg_en) begin
      sel_q <= sel_new;
      n_q   <= n_new;
      low_q <= low_new;
    end
  end

  assign low_rate_o = low_q;

  AST_CFG_HOLD_MID_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !boundary_i |=> ($stable(sel_q) && $stable(n_q))); // R7

  AST_FLAG_ONLY_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !boundary_i |=> $stable(low_rate_o)); // R8

endmodule

// File: rtl/ftg_sclk_div.sv
module ftg_sclk_div #(
  parameter int unsigned HALF_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [HALF_W-1:0] reload_len_i,
  output logic              sclk_o,
  output logic              half_end_o
);

  logic [HALF_W-1:0] cnt_q;
  logic [HALF_W-1:0] cnt_d;
  logic              sclk_q;
  logic              sclk_d;
  logic              sclk_en;

  always_comb begin
    half_end_o = (cnt_q == '0);
    sclk_en    = half_end_o;
    sclk_d     = ~sclk_q;
    if (half_end_o) begin
      cnt_d = reload_len_i - HALF_W'(1);
    end else begin
      cnt_d = cnt_q - HALF_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b1;
    end else if (sclk_en) begin
      sclk_q <= sclk_d;
    end
  end

  assign sclk_o = sclk_q;

  AST_SCLK_HOLD_IN_HALF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !half_end_o |=> $stable(sclk_o)); // R3

  AST_RELOAD_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half_end_o |-> (reload_len_i != '0)); // R4

endmodule

// File: rtl/ftg_frame_seq.sv
module ftg_frame_seq #(
  parameter int unsigned FRAME_SCLKS = 256,
  parameter int unsigned BIT_W       = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic half_end_i,
  input  logic sclk_i,
  output logic boundary_o,
  output logic fsync_o,
  output logic frame_start_o
);

  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_SCLKS - 1);

  logic [BIT_W-1:0] bit_q;
  logic [BIT_W-1:0] bit_d;
  logic             fsync_q;
  logic             fsync_d;
  logic             start_q;
  logic             start_d;
  logic             bit_edge;

  // A new bit period opens when sclk is about to fall.
  always_comb begin
    bit_edge   = half_end_i && sclk_i;
    boundary_o = bit_edge && (bit_q == LAST_BIT);
    bit_d      = boundary_o ? '0 : (bit_q + BIT_W'(1));
    fsync_d    = !boundary_o;
    start_d    = boundary_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q   <= LAST_BIT;
      fsync_q <= 1'b1;
    end else if (bit_edge) begin
      bit_q   <= bit_d;
      fsync_q <= fsync_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= 1'b0;
    end else begin
      start_q <= start_d;
    end
  end

  assign fsync_o       = fsync_q;
  assign frame_start_o = start_q;

  AST_FSYNC_FIRST_BIT_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fsync_o |-> (bit_q == '0)); // R5

  AST_FSYNC_RISE_AT_BIT1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fsync_o) |-> (bit_q == BIT_W'(1))); // R5

  AST_START_ON_FSYNC_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> $fell(fsync_o)); // R6

  AST_SCLK_LOW_AT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> !sclk_i); // R9

endmodule

// File: rtl/ftg_top.sv
module ftg_top #(
  parameter int unsigned N_W          = 5,
  parameter int unsigned FRAME_SCLKS  = 256,
  parameter int unsigned BASE_DIV     = 128,
  parameter int unsigned CLK_PER_MCLK = 4,
  parameter int unsigned MCLK_HZ      = 12_288_000,
  parameter int unsigned LOW_RATE_HZ  = 7000
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           div_sel_i,
  input  logic [N_W-1:0] div_n_i,
  output logic           sclk_o,
  output logic           fsync_o,
  output logic           frame_start_o,
  output logic           low_rate_o
);

  localparam int unsigned HALF_UNIT = (BASE_DIV * CLK_PER_MCLK) / (2 * FRAME_SCLKS);
  localparam int unsigned N_MAX     = (1 << N_W) - 1;
  localparam int unsigned HALF_MAX  = HALF_UNIT * N_MAX * ftg_pkg::MODE1_MULT;
  localparam int unsigned HALF_W    = $clog2(HALF_MAX + 1);
  localparam int unsigned BIT_W     = (FRAME_SCLKS > 2) ? $clog2(FRAME_SCLKS) : 1;

  logic              rst_sync_n;
  logic              boundary;
  logic              half_end;
  logic              sclk;
  logic [HALF_W-1:0] reload_len;

  ftg_rst_sync u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  ftg_cfg_reg #(
    .N_W         (N_W),
    .HALF_UNIT   (HALF_UNIT),
    .HALF_W      (HALF_W),
    .BASE_DIV    (BASE_DIV),
    .MCLK_HZ     (MCLK_HZ),
    .LOW_RATE_HZ (LOW_RATE_HZ)
  ) u_cfg (
    .clk_i        (clk_i),
    .rst_ni       (rst_sync_n),
    .boundary_i   (boundary),
    .div_sel_i    (div_sel_i),
    .div_n_i      (div_n_i),
    .reload_len_o (reload_len),
    .low_rate_o   (low_rate_o)
  );

  ftg_sclk_div #(
    .HALF_W (HALF_W)
  ) u_sclk (
    .clk_i        (clk_i),
    .rst_ni       (rst_sync_n),
    .reload_len_i (reload_len),
    .sclk_o       (sclk),
    .half_end_o   (half_end)
  );

  ftg_frame_seq #(
    .FRAME_SCLKS (FRAME_SCLKS),
    .BIT_W       (BIT_W)
  ) u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_sync_n),
    .half_end_i    (half_end),
    .sclk_i        (sclk),
    .boundary_o    (boundary),
    .fsync_o       (fsync_o),
    .frame_start_o (frame_start_o)
  );

  assign sclk_o = sclk;

  initial begin
    AST_HALF_UNIT_INTEGRAL: assert ((HALF_UNIT >= 1) &&
      (HALF_UNIT * 2 * FRAME_SCLKS == BASE_DIV * CLK_PER_MCLK)); // R3
  end

endmodule

// File: tb/ftg_top_tb.sv
module ftg_top_tb;

  localparam int unsigned FS   = 16;
  localparam int unsigned MHZ  = 12_288_000;
  localparam int unsigned NW   = 5;

  logic          clk;
  logic          rst_n;
  logic          div_sel;
  logic [NW-1:0] div_n;
  logic          sclk_o;
  logic          fsync_o;
  logic          frame_start_o;
  logic          low_rate_o;

  int vecs = 0;
  int errs = 0;
  bit done = 0;

  ftg_top #(
    .N_W          (NW),
    .FRAME_SCLKS  (FS),
    .BASE_DIV     (128),
    .CLK_PER_MCLK (1),
    .MCLK_HZ      (MHZ),
    .LOW_RATE_HZ  (7000)
  ) u_dut (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .div_sel_i     (div_sel),
    .div_n_i       (div_n),
    .sclk_o        (sclk_o),
    .fsync_o       (fsync_o),
    .frame_start_o (frame_start_o),
    .low_rate_o    (low_rate_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int frame_len(input int sel, input int n);
    int ne;
    ne = (n == 0) ? 1 : n;
    return 128 * ne * ((sel != 0) ? 4 : 1);
  endfunction

  task automatic sync_to_start();
    do @(negedge clk); while (!frame_start_o);
  endtask

  // Starting at a frame_start cycle, observe one whole frame.
  task automatic measure_check(input int sel, input int n, input string req);
    int len, rises, fslow, starts, s0, prev, exp_len;
    len = 0; rises = 0; fslow = 0; starts = 0;
    s0 = sclk_o; prev = sclk_o;
    do begin
      len++;
      if (!fsync_o) fslow++;
      if (frame_start_o) starts++;
      @(negedge clk);
      if (sclk_o && (prev == 0)) rises++;
      prev = sclk_o;
    end while (!frame_start_o);
    exp_len = frame_len(sel, n);
    chk(len == exp_len, {req, " frame length"}, len, exp_len);
    chk(fslow == exp_len / FS, "R5 fsync low width", fslow, exp_len / FS);
    chk(rises == FS, "R9 sclk rises per frame", rises, FS);
    chk(s0 == 0, "R9 sclk low at frame start", s0, 0);
    chk(starts == 1, "R6 start strobe width", starts, 1);
  endtask

  task automatic t_reset();
    div_sel = 1'b0;
    div_n   = 5'd3;
    rst_n   = 1'b0;
    repeat (4) @(negedge clk);
    chk(sclk_o == 1, "R1 sclk in reset", sclk_o, 1);
    chk(fsync_o == 1, "R1 fsync in reset", fsync_o, 1);
    chk(frame_start_o == 0, "R1 start in reset", frame_start_o, 0);
    chk(low_rate_o == 0, "R1 flag in reset", low_rate_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(frame_start_o == 0, "R1 no start before third edge", frame_start_o, 0);
    @(negedge clk);
    chk(frame_start_o == 1, "R1 start after third edge", frame_start_o, 1);
    chk(fsync_o == 0, "R6 fsync low with start", fsync_o, 1'b0);
    measure_check(0, 3, "R3 first frame");
  endtask

  task automatic t_mode0();
    div_sel = 1'b0; div_n = 5'd5;
    sync_to_start();
    measure_check(0, 5, "R3 mode0 N=5");
  endtask

  task automatic t_mode1();
    div_sel = 1'b1; div_n = 5'd2;
    sync_to_start();
    measure_check(1, 2, "R4 mode1 N=2");
  endtask

  task automatic t_zero_n();
    div_sel = 1'b0; div_n = 5'd0;
    sync_to_start();
    measure_check(0, 0, "R2 N=0 mode0");
    div_sel = 1'b1;
    sync_to_start();
    measure_check(1, 0, "R2 N=0 mode1");
  endtask

  task automatic t_mid_frame();
    int len;
    div_sel = 1'b0; div_n = 5'd1;
    sync_to_start();
    len = 0;
    repeat (10) begin len++; @(negedge clk); end
    div_n = 5'd5; div_sel = 1'b1;
    while (!frame_start_o) begin len++; @(negedge clk); end
    chk(len == 128, "R7 frame unchanged by mid-frame write", len, 128);
    measure_check(1, 5, "R7 new setting next frame");
  endtask

  task automatic t_low_rate();
    div_sel = 1'b0; div_n = 5'd13;
    sync_to_start();
    chk(low_rate_o == 0, "R8 N=13 mode0 not low", low_rate_o, 0);
    repeat (5) @(negedge clk);
    div_n = 5'd14;
    repeat (3) @(negedge clk);
    chk(low_rate_o == 0, "R8 flag held mid-frame", low_rate_o, 0);
    sync_to_start();
    chk(low_rate_o == 1, "R8 N=14 mode0 low", low_rate_o, 1);
    div_sel = 1'b1;
    sync_to_start();
    chk(low_rate_o == 0, "R8 N=14 mode1 not low", low_rate_o, 0);
    div_sel = 1'b0; div_n = 5'd31;
    sync_to_start();
    chk(low_rate_o == 1, "R8 N=31 mode0 low", low_rate_o, 1);
    div_n = 5'd1;
    sync_to_start();
    chk(low_rate_o == 0, "R8 N=1 mode0 not low", low_rate_o, 0);
  endtask

  initial begin
    t_reset();
    t_mode0();
    t_mode1();
    t_zero_n();
    t_mid_frame();
    t_low_rate();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      vecs++;
      errs++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

endmodule